// File: doc/BRIEF.md
# Serial EEPROM Slave Emulator

This block makes a small byte-wide storage array look like a serial EEPROM to an SPI master. The master selects the block with an active-low chip select, shifts an 8-bit command in MSB first, follows it with an address or data byte as the command needs, and reads results back on the data-out line. Six commands are decoded: read, page write, set and clear of a write-enable latch, status read and status write. The array holds 128, 256 or 512 bytes, chosen by a parameter; in the 512-byte build the ninth address bit rides in bit 3 of the read and write opcodes.

All SPI pins are oversampled by the system clock through synchronizer stages, so the block runs on one clock and detects SCK edges itself. Both idle SCK levels are accepted. Write data is collected in an 8-byte page buffer and committed only when chip select rises on a byte boundary. A commit starts a self-timed busy period whose length is a parameter in clock cycles. A 2-bit protect field in the status register guards the top quarter, the top half or all of the array. An active-low write-protect pin locks the status register. An active-low hold pin freezes the serial sequence mid-bit and releases the data-out line.

Top module: `serialEepromSlave`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and misoOe is low whenever chip select is high.
- R2: Read (0x03) followed by an address byte returns the byte at that address, then successive bytes with the address incrementing by one and wrapping from the last byte of the array to address 0.
- R3: Input bits are taken on rising SCK edges and output bits change on falling SCK edges, with SCK idling either low or high while chip select is high.
- R4: Write (0x02) with an address stores 1 to 8 data bytes within one 8-byte page, wrapping from the page's last byte to its first; the bytes are stored only if chip select rises after a whole number of data bytes.
- R5: Command 0x06 sets the write-enable latch and 0x04 clears it; status bit 1 shows the latch; a write or status write issued with the latch clear changes nothing.
- R6: Status bits 3:2 select protection: 0 none, 1 the top quarter, 2 the top half, 3 the whole array; a write aimed at a protected page stores nothing, starts no busy period and leaves the latch set.
- R7: While wpN is low a status write (0x01) leaves the protect field unchanged and starts no busy period.
- R8: While holdN is low, misoOe is low, SCK edges are ignored and miso holds; after release the transfer continues from the same bit.
- R9: A committed write or status write sets status bit 0 for BUSY_CYCLES clock cycles; the write-enable latch stays set during that time and clears when it ends.
- R10: While status bit 0 is set, every command except status read (0x05) is ignored, including 0x06.
- R11: In the 512-byte build, bit 3 of the read and write opcodes supplies address bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| wpN | input | 1 | Active-low status write protect |
| holdN | input | 1 | Active-low hold, pauses the serial sequence |
| miso | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for miso; low means the line is released |

## Verification
A wrong bit counter or command state shows at once as a shifted or missing byte on miso within the same transaction. A wrong page index or an early commit shows up on the next read-back as bytes in the wrong slots of the page. A wrong write-enable latch, protect field or busy timer surfaces in the status byte, which the bench reads straight after each commit and again after the busy window. Errors in the gating of busy and hold appear at the ports as misoOe rising when it should stay low, or as corrupted data after resumption.

// File: rtl/serialEepromPkg.sv
package serialEepromPkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  localparam int PAGE_W = 3;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  typedef enum logic [2:0] {
    S_CMD, S_ADDR, S_WDATA, S_SDATA, S_SDONE, S_OUT, S_SKIP
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadAddr;
    logic addrHi;
    logic loadRead;
    logic loadStatus;
    logic bufWrite;
    logic clearBuf;
    logic latchStatus;
    logic setWel;
    logic clrWel;
    logic commitData;
    logic commitStatus;
  } strobe_t;

endpackage

// File: rtl/spiPinSync.sv
module spiPinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic holdN,
  input  logic wpN,
  output logic csNS,
  output logic mosiS,
  output logic holdS,
  output logic wpS,
  output logic sckRise,
  output logic sckFall,
  output logic csRise
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] IDLE_LVL = 5'b10011;

  logic [STAGES-1:0][NPIN-1:0] chain;
  logic [NPIN-1:0] rawPins;
  logic [NPIN-1:0] lastPins;
  logic sckPrev;
  logic csPrev;

  assign rawPins  = {csN, sck, mosi, holdN, wpN};
  assign lastPins = chain[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= IDLE_LVL;
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) chain[s] <= chain[s-1];
      chain[0] <= rawPins;
      sckPrev  <= lastPins[3];
      csPrev   <= lastPins[4];
    end
  end

  assign csNS    = lastPins[4];
  assign mosiS   = lastPins[2];
  assign holdS   = lastPins[1];
  assign wpS     = lastPins[0];
  assign sckRise = lastPins[3] & ~sckPrev;
  assign sckFall = ~lastPins[3] & sckPrev;
  assign csRise  = lastPins[4] & ~csPrev;
endmodule

// File: rtl/serialEepromCtrl.sv
module serialEepromCtrl
  import serialEepromPkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csNS,
  input  logic       holdS,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       csRise,
  input  logic [7:0] rxByte,
  input  logic       busy,
  output strobe_t    st,
  output logic       misoOe
);
  ctrlState_t state, stateNext;
  logic [2:0] bitCnt, bitCntNext;
  logic       isRead, isReadNext;
  logic       addrHi, addrHiNext;
  logic [7:0] opMask;
  logic [7:0] opMasked;

  // Parameter picks whether opcode bit 3 is an address bit.
  if (ADDR_W > 8) begin : g_addrInOp
    assign opMask = 8'hF7;
  end else begin : g_plainOp
    assign opMask = 8'hFF;
  end

  assign opMasked = rxByte & opMask;

  always_comb begin
    st         = '0;
    st.addrHi  = addrHi;
    stateNext  = state;
    bitCntNext = bitCnt;
    isReadNext = isRead;
    addrHiNext = addrHi;
    if (csNS) begin
      stateNext  = S_CMD;
      bitCntNext = 3'd0;
      if (csRise && bitCnt == 3'd0) begin
        st.commitData   = (state == S_WDATA);
        st.commitStatus = (state == S_SDONE);
      end
    end else if (holdS) begin
      if (sckFall && state == S_OUT) st.shiftOut = 1'b1;
      if (sckRise) begin
        st.shiftIn = 1'b1;
        bitCntNext = bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          unique case (state)
            S_CMD: begin
              if (busy && rxByte != OP_RDSR) begin
                stateNext = S_SKIP;
              end else if (rxByte == OP_WREN) begin
                st.setWel = 1'b1;
                stateNext = S_SKIP;
              end else if (rxByte == OP_WRDI) begin
                st.clrWel = 1'b1;
                stateNext = S_SKIP;
              end else if (rxByte == OP_RDSR) begin
                st.loadStatus = 1'b1;
                isReadNext    = 1'b0;
                stateNext     = S_OUT;
              end else if (rxByte == OP_WRSR) begin
                stateNext = S_SDATA;
              end else if (opMasked == OP_READ) begin
                isReadNext = 1'b1;
                addrHiNext = rxByte[3];
                stateNext  = S_ADDR;
              end else if (opMasked == OP_WRITE) begin
                isReadNext  = 1'b0;
                addrHiNext  = rxByte[3];
                st.clearBuf = 1'b1;
                stateNext   = S_ADDR;
              end else begin
                stateNext = S_SKIP;
              end
            end
            S_ADDR: begin
              st.loadAddr = 1'b1;
              if (isRead) begin
                st.loadRead = 1'b1;
                stateNext   = S_OUT;
              end else begin
                stateNext = S_WDATA;
              end
            end
            S_WDATA: st.bufWrite = 1'b1;
            S_SDATA: begin
              st.latchStatus = 1'b1;
              stateNext      = S_SDONE;
            end
            S_OUT: begin
              st.loadRead   = isRead;
              st.loadStatus = ~isRead;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_CMD;
      bitCnt <= 3'd0;
      isRead <= 1'b0;
      addrHi <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
      isRead <= isReadNext;
      addrHi <= addrHiNext;
    end
  end

  assign misoOe = !csNS && holdS && state == S_OUT;
endmodule

// File: rtl/serialEepromData.sv
module serialEepromData
  import serialEepromPkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  input  logic       mosiS,
  input  logic       wpS,
  output logic [7:0] rxByte,
  output logic       busy,
  output logic       wel,
  output logic       miso
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            mem [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [7:0]            shiftInReg;
  logic [7:0]            shiftOutReg;
  logic [ADDR_W-1:0]     addr;
  logic [ADDR_W-1:0]     newAddr;
  logic [ADDR_W-1:0]     readAddr;
  logic [8:0]            fullAddr;
  logic [1:0]            protField;
  logic [1:0]            pendProt;
  logic [CNT_W-1:0]      busyCnt;
  logic [1:0]            pageTop;
  logic                  pageLocked;
  logic [7:0]            statusByte;

  assign rxByte   = {shiftInReg[6:0], mosiS};
  assign fullAddr = {st.addrHi, rxByte};
  assign newAddr  = fullAddr[ADDR_W-1:0];
  assign readAddr = st.loadAddr ? newAddr : addr;

  assign busy       = (busyCnt != '0);
  assign statusByte = {4'b0000, protField, wel, busy};

  assign pageTop    = addr[ADDR_W-1 -: 2];
  assign pageLocked = (protField == 2'd3) ||
                      (protField == 2'd2 && pageTop[1]) ||
                      (protField == 2'd1 && pageTop == 2'b11);

  // Serial shifters and address pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftInReg  <= 8'h00;
      shiftOutReg <= 8'h00;
      miso        <= 1'b0;
      addr        <= '0;
      pendProt    <= 2'd0;
      pageMask    <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'h00;
    end else begin
      if (st.shiftIn) shiftInReg <= rxByte;
      if (st.shiftOut) begin
        miso        <= shiftOutReg[7];
        shiftOutReg <= {shiftOutReg[6:0], 1'b0};
      end
      if (st.loadRead) begin
        shiftOutReg <= mem[readAddr];
        addr        <= readAddr + 1'b1;
      end else if (st.loadAddr) begin
        addr <= newAddr;
      end
      if (st.loadStatus) shiftOutReg <= statusByte;
      if (st.clearBuf) pageMask <= '0;
      if (st.bufWrite) begin
        pageBuf[addr[PAGE_W-1:0]]  <= rxByte;
        pageMask[addr[PAGE_W-1:0]] <= 1'b1;
        addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
      end
      if (st.latchStatus) pendProt <= rxByte[3:2];
    end
  end

  // Array, status register, latch and busy timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      protField <= 2'd0;
      wel       <= 1'b0;
      busyCnt   <= '0;
    end else begin
      if (busy) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == CNT_W'(1)) wel <= 1'b0;
      end
      if (st.setWel) wel <= 1'b1;
      if (st.clrWel) wel <= 1'b0;
      if (st.commitData && wel && (pageMask != '0) && !pageLocked) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (pageMask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
        busyCnt <= CNT_W'(BUSY_CYCLES);
      end
      if (st.commitStatus && wel && wpS) begin
        protField <= pendProt;
        busyCnt   <= CNT_W'(BUSY_CYCLES);
      end
    end
  end
endmodule

// File: rtl/serialEepromSlave.sv
module serialEepromSlave
  import serialEepromPkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic wpN,
  input  logic holdN,
  output logic miso,
  output logic misoOe
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic csNS, mosiS, holdS, wpS, sckRise, sckFall, csRise;
  logic [7:0] rxByte;
  logic busy, wel;
  strobe_t st;

  spiPinSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .holdN(holdN), .wpN(wpN), .csNS(csNS), .mosiS(mosiS), .holdS(holdS),
    .wpS(wpS), .sckRise(sckRise), .sckFall(sckFall), .csRise(csRise)
  );

  serialEepromCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csNS(csNS), .holdS(holdS), .sckRise(sckRise),
    .sckFall(sckFall), .csRise(csRise), .rxByte(rxByte), .busy(busy),
    .st(st), .misoOe(misoOe)
  );

  serialEepromData #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .mosiS(mosiS), .wpS(wpS),
    .rxByte(rxByte), .busy(busy), .wel(wel), .miso(miso)
  );
endmodule

// File: rtl/serialEepromChecker.sv
module serialEepromChecker (
  input logic clk,
  input logic rstN,
  input logic csNS,
  input logic holdS,
  input logic miso,
  input logic misoOe,
  input logic busy,
  input logic wel
);
  // R1: a deselected block keeps its output released
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (csNS && $past(csNS)) |-> !misoOe);

  // R5: a busy period only ever starts with the latch set
  a_r5_busy_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

  // R8: data out is frozen across a held cycle
  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (!holdS && $past(!holdS)) |-> $stable(miso));

  // R9: the latch is clear once the busy period ends
  a_r9_latch_drops: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R10: the latch cannot be set while busy
  a_r10_no_set_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !$past(busy));
endmodule

bind serialEepromSlave serialEepromChecker u_checker (
  .clk(clk), .rstN(rstN), .csNS(csNS), .holdS(holdS), .miso(miso),
  .misoOe(misoOe), .busy(busy), .wel(wel)
);

// File: tb/test_serialEepromSlave.sv
module test_serialEepromSlave;
  localparam int BUSY = 1000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, mosi = 1'b0, wpN = 1'b1, holdN = 1'b1;
  logic miso, misoOe;
  logic mode3 = 1'b0;
  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  serialEepromSlave #(.DEPTH(512), .BUSY_CYCLES(BUSY)) i_serialEepromSlave (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .wpN(wpN),
    .holdN(holdN), .miso(miso), .misoOe(misoOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic selectOn();
    sck = mode3;
    ticks(HALF);
    csN = 1'b0;
    ticks(HALF);
  endtask

  task automatic selectOff();
    if (!mode3) sck = 1'b0;
    ticks(HALF);
    csN = 1'b1;
    ticks(2 * HALF);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0;
      mosi = tx[7-i];
      ticks(HALF);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      ticks(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic sendCmd(input logic [7:0] op);
    logic [7:0] d;
    selectOn(); xfer(op, d); selectOff();
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] d;
    selectOn(); xfer(8'h05, d); xfer(8'h00, s); selectOff();
  endtask

  task automatic writeStatus(input logic [7:0] v);
    logic [7:0] d;
    selectOn(); xfer(8'h01, d); xfer(v, d); selectOff();
  endtask

  task automatic writeBytes(input logic [8:0] a, input int n);
    logic [7:0] d;
    selectOn();
    xfer(8'h02 | {4'h0, a[8], 3'b000}, d);
    xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    selectOff();
  endtask

  task automatic readBytes(input logic [8:0] a, input int n);
    logic [7:0] d;
    selectOn();
    xfer(8'h03 | {4'h0, a[8], 3'b000}, d);
    xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    selectOff();
  endtask

  task automatic waitIdle();
    ticks(BUSY + 50);
  endtask

  task automatic tReset();
    logic [7:0] s;
    check("R1 oe after reset", misoOe, 1'b0);
    readStatus(s);
    check("R1 status after reset", s, 8'h00);
    readBytes(9'h000, 2);
    check("R1 erased byte 0", rbuf[0], 8'hFF);
    check("R1 erased byte 1", rbuf[1], 8'hFF);
  endtask

  task automatic tLatch();
    logic [7:0] s;
    sendCmd(8'h06); readStatus(s);
    check("R5 latch set", s, 8'h02);
    sendCmd(8'h04); readStatus(s);
    check("R5 latch cleared", s, 8'h00);
    wbuf[0] = 8'h12;
    writeBytes(9'h020, 1);
    readStatus(s);
    check("R5 no busy without latch", s, 8'h00);
    readBytes(9'h020, 1);
    check("R5 write without latch ignored", rbuf[0], 8'hFF);
  endtask

  task automatic tPage();
    logic [7:0] s;
    sendCmd(8'h06);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    writeBytes(9'h010, 3);
    readStatus(s);
    check("R9 busy with latch held", s, 8'h03);
    ticks(BUSY);
    readStatus(s);
    check("R9 ready and latch cleared", s, 8'h00);
    readBytes(9'h010, 3);
    check("R4 page byte 0", rbuf[0], 8'hA1);
    check("R2 sequential read 1", rbuf[1], 8'hA2);
    check("R2 sequential read 2", rbuf[2], 8'hA3);
  endtask

  task automatic tWrap();
    sendCmd(8'h06);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hB0 + 8'(i);
    writeBytes(9'h01E, 4);
    waitIdle();
    readBytes(9'h018, 8);
    check("R4 wrap to page start 0x18", rbuf[0], 8'hB2);
    check("R4 wrap to page start 0x19", rbuf[1], 8'hB3);
    check("R4 untouched 0x1A", rbuf[2], 8'hFF);
    check("R4 first byte at 0x1E", rbuf[6], 8'hB0);
    check("R4 second byte at 0x1F", rbuf[7], 8'hB1);
  endtask

  task automatic tAbort();
    logic [7:0] d, s;
    sendCmd(8'h06);
    selectOn();
    xfer(8'h02, d); xfer(8'h30, d); xfer(8'hC1, d); xferBits(8'hC2, 4, d);
    selectOff();
    readStatus(s);
    check("R4 partial byte no commit status", s, 8'h02);
    readBytes(9'h030, 1);
    check("R4 partial byte no commit data", rbuf[0], 8'hFF);
    sendCmd(8'h04);
  endtask

  task automatic tRollover();
    sendCmd(8'h06);
    wbuf[0] = 8'h5A;
    writeBytes(9'h1FF, 1);
    waitIdle();
    readBytes(9'h1FF, 2);
    check("R11 high address via opcode bit", rbuf[0], 8'h5A);
    check("R2 rollover to address 0", rbuf[1], 8'hFF);
    readBytes(9'h0FF, 1);
    check("R11 low twin untouched", rbuf[0], 8'hFF);
  endtask

  task automatic tMode3();
    mode3 = 1'b1;
    readBytes(9'h010, 1);
    check("R3 read with high idle clock", rbuf[0], 8'hA1);
    sendCmd(8'h06);
    wbuf[0] = 8'h77;
    writeBytes(9'h040, 1);
    waitIdle();
    readBytes(9'h040, 1);
    check("R3 write with high idle clock", rbuf[0], 8'h77);
    mode3 = 1'b0;
  endtask

  task automatic tBusy();
    logic [7:0] d, s;
    sendCmd(8'h06);
    wbuf[0] = 8'h99;
    writeBytes(9'h050, 1);
    selectOn();
    xfer(8'h03, d); xfer(8'h50, d); xfer(8'h00, d);
    check("R10 read ignored while busy", misoOe, 1'b0);
    selectOff();
    sendCmd(8'h06);
    waitIdle();
    readStatus(s);
    check("R10 latch set ignored while busy", s, 8'h00);
    readBytes(9'h050, 1);
    check("R10 prior write landed", rbuf[0], 8'h99);
  endtask

  task automatic tHold();
    logic [7:0] d, r0, ra, rb;
    selectOn();
    xfer(8'h03, d); xfer(8'h10, d); xfer(8'h00, r0);
    xferBits(8'h00, 4, ra);
    holdN = 1'b0;
    ticks(HALF);
    check("R8 output released in hold", misoOe, 1'b0);
    for (int i = 0; i < 2; i++) begin
      sck = 1'b0; mosi = 1'b1; ticks(HALF);
      sck = 1'b1; ticks(HALF);
    end
    holdN = 1'b1;
    ticks(HALF);
    check("R8 output back after hold", misoOe, 1'b1);
    xferBits(8'h00, 4, rb);
    selectOff();
    check("R8 byte before hold", r0, 8'hA1);
    check("R8 byte resumed across hold", {ra[3:0], rb[3:0]}, 8'hA2);
  endtask

  task automatic tProtect();
    logic [7:0] s;
    sendCmd(8'h06); writeStatus(8'h04); waitIdle();
    readStatus(s);
    check("R6 quarter field stored", s, 8'h04);
    sendCmd(8'h06);
    wbuf[0] = 8'h11; writeBytes(9'h180, 1);
    readStatus(s);
    check("R6 quarter blocks top, latch kept", s, 8'h06);
    readBytes(9'h180, 1);
    check("R6 quarter protected data", rbuf[0], 8'hFF);
    wbuf[0] = 8'h22; writeBytes(9'h100, 1); waitIdle();
    readBytes(9'h100, 1);
    check("R6 quarter leaves 0x100 open", rbuf[0], 8'h22);
    sendCmd(8'h06); writeStatus(8'h08); waitIdle();
    sendCmd(8'h06);
    wbuf[0] = 8'h33; writeBytes(9'h100, 1);
    wbuf[0] = 8'h44; writeBytes(9'h0F8, 1); waitIdle();
    readBytes(9'h100, 1);
    check("R6 half protects 0x100", rbuf[0], 8'h22);
    readBytes(9'h0F8, 1);
    check("R6 half leaves 0x0F8 open", rbuf[0], 8'h44);
    sendCmd(8'h06); writeStatus(8'h0C); waitIdle();
    sendCmd(8'h06);
    wbuf[0] = 8'h55; writeBytes(9'h000, 1);
    readBytes(9'h000, 1);
    check("R6 full protects 0x000", rbuf[0], 8'hFF);
    readStatus(s);
    check("R6 full field and latch", s, 8'h0E);
  endtask

  task automatic tWp();
    logic [7:0] s;
    wpN = 1'b0;
    writeStatus(8'h00);
    readStatus(s);
    check("R7 status locked by pin", s, 8'h0E);
    wpN = 1'b1;
    ticks(HALF);
    writeStatus(8'h00);
    waitIdle();
    readStatus(s);
    check("R7 status write after pin release", s, 8'h00);
  endtask

  initial begin
    ticks(10);
    rstN = 1'b1;
    ticks(10);
    tReset();
    tLatch();
    tPage();
    tWrap();
    tAbort();
    tRollover();
    tMode3();
    tBusy();
    tHold();
    tProtect();
    tWp();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule